// File: doc/BRIEF.md
# Video Processor Host Register Interface

This block is the host-facing register file of a video processor. A host selects one of eight byte-wide register slots with a 3-bit index and strobes either a read or a write. Behind the slots sit a control byte, a mask byte, a status byte carrying a vertical-blank flag, a pair of scroll bytes and a 14-bit video-memory address. A data slot passes host accesses through to an external video-memory port. The address then steps forward on its own, so a host can stream consecutive bytes, or walk down a column when the step is 32.

Two-byte quantities (scroll X/Y and the address) are loaded through one index each, using two single-byte writes. One shared first/second toggle steers which byte a write lands in. Reading status puts the toggle back to its first state, so software can always resynchronise. Every read returns a persistent data latch. Readable slots refresh the latch. Write-only slots leave it holding whatever was read last.

Top module: `vid_reg_if`

## Requirements
- R1: After reset, `rdata`, `ctrl`, `mask`, `scroll_x`, `scroll_y` and `vram_addr` are zero, the vertical-blank flag is clear and the toggle is in its first state.
- R2: A read of index 0 (control) or index 1 (mask) loads that register into the latch. `rdata` shows the value from the cycle after the strobe.
- R3: A read of index 3, 4, 5 or 6 leaves `rdata` unchanged.
- R4: The status value is bit 7 = vertical-blank flag, with bits 6:0 reading as zero. A `vblank_set` pulse sets the flag. A read of index 2 latches the status value, then clears the flag and returns the toggle to its first state. A `vblank_set` pulse in the same cycle as that read leaves the flag set.
- R5: A write to index 5 loads `scroll_x` when the toggle is in its first state and `scroll_y` otherwise. The toggle flips after each such write.
- R6: A write to index 6 loads address bits 13:8 from `wdata[5:0]` when the toggle is in its first state, and address bits 7:0 otherwise. The toggle flips after each such write.
- R7: A read of index 7 raises `vram_rd` in the same cycle, with `vram_addr` giving the current address, and loads `vram_rdata` into the latch. The address then grows by 32 when `ctrl` bit 2 is 1, and by 1 otherwise, wrapping modulo 2^14.
- R8: A write to index 7 raises `vram_wr` in the same cycle, with `vram_wdata` = `wdata` at the current address. The address then steps by the same rule as R7, and `rdata` is unchanged.
- R9: When `rd_stb` and `wr_stb` are high together, only the read takes effect. No register is written and `vram_wr` stays low.
- R10: Writes to index 2, 3 or 4 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 3 | Register index |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| vblank_set | input | 1 | Pulse that sets the vertical-blank flag |
| rdata | output | 8 | Data latch contents |
| ctrl | output | 8 | Control register (bit 2 selects step 32) |
| mask | output | 8 | Mask register |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| vram_addr | output | 14 | Current video-memory address |
| vram_rd | output | 1 | Video-memory read strobe |
| vram_wr | output | 1 | Video-memory write strobe |
| vram_wdata | output | 8 | Video-memory write data |
| vram_rdata | input | 8 | Video-memory read data, same cycle as `vram_rd` |

## Verification
The host is driven through several access patterns, and each one separates a particular fault.

- **Alternating writes to the scroll and address slots.** These expose a toggle that flips at the wrong time or fails to be shared. A status read between two address writes shows whether the read resets the toggle.
- **Reads of write-only slots between data reads.** These tell a latch that holds its value apart from one that reloads or clears.
- **Streaming data reads at both step sizes.** The start addresses are close to 2^14, so the runs catch a wrong step and a missing wrap.
- **Simultaneous strobes.** These separate read priority from a design that also commits the write.

// File: rtl/vri_pkg.sv
package vri_pkg;
  typedef enum logic [2:0] {
    IDX_CTRL = 3'd0,
    IDX_MASK = 3'd1,
    IDX_STAT = 3'd2,
    IDX_RSV3 = 3'd3,
    IDX_RSV4 = 3'd4,
    IDX_SCRL = 3'd5,
    IDX_ADDR = 3'd6,
    IDX_DATA = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic ld_ctrl;
    logic ld_mask;
    logic ld_scroll;
    logic ld_addr;
    logic wr_data;
    logic rd_ctrl;
    logic rd_mask;
    logic rd_stat;
    logic rd_data;
  } act_t;
endpackage

// File: rtl/vri_decode.sv
module vri_decode
  import vri_pkg::*;
(
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic [2:0] sel,
  output act_t       act
);
  logic     wr_ok;
  reg_idx_e idx;

  assign wr_ok = wr_stb & ~rd_stb;
  assign idx   = reg_idx_e'(sel);

  always_comb begin
    act = '0;
    if (rd_stb) begin
      case (idx)
        IDX_CTRL: act.rd_ctrl = 1'b1;
        IDX_MASK: act.rd_mask = 1'b1;
        IDX_STAT: act.rd_stat = 1'b1;
        IDX_DATA: act.rd_data = 1'b1;
        default:  ;
      endcase
    end else if (wr_ok) begin
      case (idx)
        IDX_CTRL: act.ld_ctrl   = 1'b1;
        IDX_MASK: act.ld_mask   = 1'b1;
        IDX_SCRL: act.ld_scroll = 1'b1;
        IDX_ADDR: act.ld_addr   = 1'b1;
        IDX_DATA: act.wr_data   = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/vri_vaddr.sv
module vri_vaddr #(
  parameter int AW       = 14,
  parameter int DW       = 8,
  parameter int STEP_BIG = 32
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          ld_en,
  input  logic          ld_hi,
  input  logic [DW-1:0] wdata,
  input  logic          step_en,
  input  logic          big_step,
  output logic [AW-1:0] addr
);
  localparam int HI_W = AW - DW;
  localparam logic [AW-1:0] STEP_L = AW'(STEP_BIG);
  localparam logic [AW-1:0] STEP_S = AW'(1);

  logic [AW-1:0] addr_q, addr_n;
  logic          addr_en;

  assign addr_en = ld_en | step_en;

  always_comb begin
    addr_n = addr_q;
    if (ld_en) begin
      if (ld_hi) addr_n = {wdata[HI_W-1:0], addr_q[DW-1:0]};
      else       addr_n = {addr_q[AW-1:DW], wdata};
    end else if (step_en) begin
      addr_n = addr_q + (big_step ? STEP_L : STEP_S);
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_n;
  end

  assign addr = addr_q;
endmodule

// File: rtl/vri_rdlatch.sv
module vri_rdlatch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_r;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)     q_r <= '0;
    else if (ld_en) q_r <= ld_val;
  end

  assign q = q_r;
endmodule

// File: rtl/vid_reg_if.sv
module vid_reg_if
  import vri_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 14,
  parameter int INC_BIT  = 2,
  parameter int VBL_BIT  = 7,
  parameter int STEP_BIG = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    sel,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  input  logic          vblank_set,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ctrl,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] scroll_x,
  output logic [DW-1:0] scroll_y,
  output logic [AW-1:0] vram_addr,
  output logic          vram_rd,
  output logic          vram_wr,
  output logic [DW-1:0] vram_wdata,
  input  logic [DW-1:0] vram_rdata
);
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  act_t act;
  vri_decode u_dec (.rd_stb(rd_stb), .wr_stb(wr_stb), .sel(sel), .act(act));

  logic [DW-1:0] ctrl_q, ctrl_n, mask_q, mask_n, sx_q, sx_n, sy_q, sy_n;
  logic          toggle_q, toggle_n, vblank_q, vblank_n;
  logic [DW-1:0] status_v, lat_val;
  logic          lat_en, step_en;

  always_comb begin
    status_v          = '0;
    status_v[VBL_BIT] = vblank_q;
  end

  always_comb begin
    ctrl_n   = act.ld_ctrl ? wdata : ctrl_q;
    mask_n   = act.ld_mask ? wdata : mask_q;
    sx_n     = (act.ld_scroll && !toggle_q) ? wdata : sx_q;
    sy_n     = (act.ld_scroll &&  toggle_q) ? wdata : sy_q;
    toggle_n = toggle_q;
    if (act.rd_stat)                        toggle_n = 1'b0;
    else if (act.ld_scroll || act.ld_addr)  toggle_n = ~toggle_q;
    vblank_n = vblank_q;
    if (vblank_set)        vblank_n = 1'b1;
    else if (act.rd_stat)  vblank_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      sx_q     <= '0;
      sy_q     <= '0;
      toggle_q <= 1'b0;
      vblank_q <= 1'b0;
    end else begin
      if (act.ld_ctrl)   ctrl_q <= ctrl_n;
      if (act.ld_mask)   mask_q <= mask_n;
      if (act.ld_scroll) begin
        sx_q <= sx_n;
        sy_q <= sy_n;
      end
      toggle_q <= toggle_n;
      vblank_q <= vblank_n;
    end
  end

  assign step_en = act.rd_data | act.wr_data;

  vri_vaddr #(.AW(AW), .DW(DW), .STEP_BIG(STEP_BIG)) u_addr (
    .clk(clk), .rst_q(rst_q), .ld_en(act.ld_addr), .ld_hi(~toggle_q),
    .wdata(wdata), .step_en(step_en), .big_step(ctrl_q[INC_BIT]),
    .addr(vram_addr)
  );

  always_comb begin
    lat_en  = act.rd_ctrl | act.rd_mask | act.rd_stat | act.rd_data;
    lat_val = vram_rdata;
    if (act.rd_ctrl)      lat_val = ctrl_q;
    else if (act.rd_mask) lat_val = mask_q;
    else if (act.rd_stat) lat_val = status_v;
  end

  vri_rdlatch #(.DW(DW)) u_lat (
    .clk(clk), .rst_q(rst_q), .ld_en(lat_en), .ld_val(lat_val), .q(rdata)
  );

  assign ctrl       = ctrl_q;
  assign mask       = mask_q;
  assign scroll_x   = sx_q;
  assign scroll_y   = sy_q;
  assign vram_rd    = act.rd_data;
  assign vram_wr    = act.wr_data;
  assign vram_wdata = wdata;
endmodule

// File: rtl/vri_chk.sv
module vri_chk #(
  parameter int DW = 8,
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_q,
  input logic [2:0]    sel,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic [DW-1:0] wdata,
  input logic          vblank_set,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] ctrl,
  input logic [DW-1:0] scroll_x,
  input logic [AW-1:0] vram_addr,
  input logic          vram_rd,
  input logic          vram_wr,
  input logic [DW-1:0] vram_rdata,
  input logic          toggle_q,
  input logic          vblank_q
);
  // R3
  wo_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_stb && (sel == 3'd3 || sel == 3'd4 || sel == 3'd5 || sel == 3'd6)) |=> $stable(rdata));

  // R4
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_stb && sel == 3'd2 && !vblank_set) |=> (!vblank_q && !toggle_q));

  // R5
  scroll_first_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_stb && !rd_stb && sel == 3'd5 && !toggle_q) |=> (scroll_x == $past(wdata) && toggle_q));

  // R7
  data_rd_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_stb && sel == 3'd7) |=> (rdata == $past(vram_rdata)));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (vram_rd || vram_wr) |=>
      (vram_addr == AW'($past(vram_addr) + ($past(ctrl[2]) ? AW'(32) : AW'(1)))));

  // R8
  wr_src_chk: assert property (@(posedge clk) disable iff (!rst_q)
    vram_wr |-> (wr_stb && sel == 3'd7));

  // R9
  rd_prio_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rd_stb |-> !vram_wr);
endmodule

bind vid_reg_if vri_chk #(.DW(DW), .AW(AW)) u_vri_chk (
  .clk(clk), .rst_q(rst_q), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .wdata(wdata), .vblank_set(vblank_set), .rdata(rdata), .ctrl(ctrl),
  .scroll_x(scroll_x), .vram_addr(vram_addr), .vram_rd(vram_rd),
  .vram_wr(vram_wr), .vram_rdata(vram_rdata), .toggle_q(toggle_q),
  .vblank_q(vblank_q)
);

// File: tb/test_vid_reg_if.sv
`timescale 1ns/1ps
module test_vid_reg_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel = '0;
  logic        rd_stb = 1'b0, wr_stb = 1'b0, vblank_set = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, ctrl, mask, scroll_x, scroll_y, vram_wdata, vram_rdata;
  logic [13:0] vram_addr;
  logic        vram_rd, vram_wr;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  assign vram_rdata = vram_addr[7:0] ^ {2'b00, vram_addr[13:8]};

  vid_reg_if i_vid_reg_if (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .vblank_set(vblank_set), .rdata(rdata), .ctrl(ctrl),
    .mask(mask), .scroll_x(scroll_x), .scroll_y(scroll_y),
    .vram_addr(vram_addr), .vram_rd(vram_rd), .vram_wr(vram_wr),
    .vram_wdata(vram_wdata), .vram_rdata(vram_rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic r, input logic w, input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    rd_stb = r; wr_stb = w; sel = s; wdata = d;
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0;
  endtask

  // {rd, wr, sel, wdata, expected rdata after the access}
  localparam logic [20:0] VEC [0:17] = '{
    {1'b0, 1'b1, 3'd0, 8'h5A, 8'h00},  // R2 set control
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h5A},  // R2
    {1'b0, 1'b1, 3'd1, 8'h3C, 8'h5A},
    {1'b1, 1'b0, 3'd1, 8'h00, 8'h3C},  // R2
    {1'b1, 1'b0, 3'd5, 8'h00, 8'h3C},  // R3
    {1'b0, 1'b1, 3'd6, 8'hFF, 8'h3C},  // R6 high
    {1'b0, 1'b1, 3'd6, 8'hF0, 8'h3C},  // R6 low
    {1'b1, 1'b0, 3'd7, 8'h00, 8'hCF},  // R7 at 3FF0
    {1'b1, 1'b0, 3'd7, 8'h00, 8'hCE},  // R7 at 3FF1
    {1'b1, 1'b0, 3'd6, 8'h00, 8'hCE},  // R3
    {1'b1, 1'b0, 3'd2, 8'h00, 8'h00},  // R4
    {1'b0, 1'b1, 3'd6, 8'h12, 8'h00},
    {1'b0, 1'b1, 3'd6, 8'h34, 8'h00},
    {1'b1, 1'b0, 3'd7, 8'h00, 8'h26},  // R7 at 1234
    {1'b0, 1'b1, 3'd0, 8'h04, 8'h26},  // step 32
    {1'b1, 1'b0, 3'd7, 8'h00, 8'h27},  // R7 at 1235
    {1'b1, 1'b0, 3'd7, 8'h00, 8'h47},  // R7 at 1255
    {1'b1, 1'b0, 3'd4, 8'h00, 8'h47}   // R3
  };

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 rdata", 16'(rdata), 16'h0);
    chk("R1 ctrl", 16'(ctrl), 16'h0);
    chk("R1 mask", 16'(mask), 16'h0);
    chk("R1 scroll", {scroll_x, scroll_y}, 16'h0);
    chk("R1 addr", 16'(vram_addr), 16'h0);

    for (int i = 0; i < 18; i++) begin
      op(VEC[i][20], VEC[i][19], VEC[i][18:16], VEC[i][15:8]);
      chk($sformatf("R2/R3/R6/R7 vector %0d", i), 16'(rdata), 16'(VEC[i][7:0]));
    end
    chk("R7 addr after stream", 16'(vram_addr), 16'h1275);

    // R4 flag set, read, cleared
    @(negedge clk); vblank_set = 1'b1; @(negedge clk); vblank_set = 1'b0;
    op(1'b1, 1'b0, 3'd2, 8'h00);
    chk("R4 status set", 16'(rdata), 16'h80);
    op(1'b1, 1'b0, 3'd2, 8'h00);
    chk("R4 status cleared", 16'(rdata), 16'h00);
    // R4 set wins over read clear
    @(negedge clk); vblank_set = 1'b1; rd_stb = 1'b1; sel = 3'd2;
    @(negedge clk); vblank_set = 1'b0; rd_stb = 1'b0;
    chk("R4 same-cycle read value", 16'(rdata), 16'h00);
    op(1'b1, 1'b0, 3'd2, 8'h00);
    chk("R4 set wins", 16'(rdata), 16'h80);
    // R4 toggle reset by status read
    op(1'b0, 1'b1, 3'd6, 8'h01);
    op(1'b1, 1'b0, 3'd2, 8'h00);
    op(1'b0, 1'b1, 3'd6, 8'h02);
    op(1'b0, 1'b1, 3'd6, 8'h03);
    chk("R4 toggle reset", 16'(vram_addr), 16'h0203);

    // R5
    op(1'b0, 1'b1, 3'd5, 8'h11);
    op(1'b0, 1'b1, 3'd5, 8'h22);
    chk("R5 scroll", {scroll_x, scroll_y}, 16'h1122);
    op(1'b0, 1'b1, 3'd5, 8'h33);
    chk("R5 third write to x", {scroll_x, scroll_y}, 16'h3322);
    op(1'b1, 1'b0, 3'd2, 8'h00);

    // R7 wrap with step 32 (ctrl bit 2 = 1 already)
    op(1'b0, 1'b1, 3'd6, 8'h3F);
    op(1'b0, 1'b1, 3'd6, 8'hF0);
    @(negedge clk); rd_stb = 1'b1; sel = 3'd7; #1;
    chk("R7 vram_rd", 16'(vram_rd), 16'h1);
    chk("R7 addr during read", 16'(vram_addr), 16'h3FF0);
    @(negedge clk); rd_stb = 1'b0;
    chk("R7 wrap 32", 16'(vram_addr), 16'h0010);
    // R7 wrap with step 1
    op(1'b0, 1'b1, 3'd0, 8'h00);
    op(1'b0, 1'b1, 3'd6, 8'h3F);
    op(1'b0, 1'b1, 3'd6, 8'hFF);
    op(1'b1, 1'b0, 3'd7, 8'h00);
    chk("R7 wrap 1 data", 16'(rdata), 16'h00C0);
    chk("R7 wrap 1", 16'(vram_addr), 16'h0000);

    // R8
    op(1'b0, 1'b1, 3'd6, 8'h01);
    op(1'b0, 1'b1, 3'd6, 8'h00);
    @(negedge clk); wr_stb = 1'b1; sel = 3'd7; wdata = 8'hAB; #1;
    chk("R8 vram_wr", 16'(vram_wr), 16'h1);
    chk("R8 vram_wdata", 16'(vram_wdata), 16'hAB);
    chk("R8 addr", 16'(vram_addr), 16'h0100);
    @(negedge clk); wr_stb = 1'b0;
    chk("R8 step", 16'(vram_addr), 16'h0101);
    chk("R8 rdata kept", 16'(rdata), 16'h00C0);

    // R9
    op(1'b0, 1'b1, 3'd0, 8'h81);
    @(negedge clk); rd_stb = 1'b1; wr_stb = 1'b1; sel = 3'd0; wdata = 8'h7E;
    @(negedge clk); rd_stb = 1'b0; wr_stb = 1'b0;
    chk("R9 ctrl kept", 16'(ctrl), 16'h81);
    chk("R9 read taken", 16'(rdata), 16'h81);
    @(negedge clk); rd_stb = 1'b1; wr_stb = 1'b1; sel = 3'd7; #1;
    chk("R9 no vram_wr", 16'(vram_wr), 16'h0);
    @(negedge clk); rd_stb = 1'b0; wr_stb = 1'b0;
    chk("R9 read step", 16'(vram_addr), 16'h0102);

    // R10
    op(1'b0, 1'b1, 3'd2, 8'hFF);
    op(1'b0, 1'b1, 3'd3, 8'hFF);
    op(1'b0, 1'b1, 3'd4, 8'hFF);
    chk("R10 ctrl", 16'(ctrl), 16'h81);
    chk("R10 mask", 16'(mask), 16'h3C);
    chk("R10 scroll", {scroll_x, scroll_y}, 16'h3322);
    chk("R10 addr", 16'(vram_addr), 16'h0102);
    op(1'b1, 1'b0, 3'd2, 8'h00);
    chk("R10 status", 16'(rdata), 16'h00);

    // R1 reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 rdata after reset", 16'(rdata), 16'h0);
    chk("R1 addr after reset", 16'(vram_addr), 16'h0);
    chk("R1 ctrl after reset", 16'(ctrl), 16'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule